// File: doc/BRIEF.md
# Preloaded Up-Counting Interval Timer

This block is a periodic interval timer with a 16-bit counter and a byte-wide register port. Software writes a start value into a preload register and then issues a run command. On every cycle where the external 160 kHz tick enable is high, the counter steps upward. When it steps past its all-ones value, it reloads the preload value in the same cycle and keeps counting. The number of ticks in one period is therefore 65536 minus the preload. A rate of f Hz needs a preload of 65536 − 160000/f. For example, 10 kHz uses 0xFFF0, which gives 16 ticks per period.

Each rollover sets a sticky pending flag in the interrupt-control byte. The same byte holds a 3-bit priority level and an enable bit. The request output is high while both the flag and the enable are set. The level output always carries the stored priority. Software clears the flag by writing a one to its bit. Bus decoding, vector generation and arbitration between several timers live outside the block.

Top module: `ivl_timer`

## Requirements
- R1: After reset, the counter, the preload and the interrupt-control byte are all zero, the timer is stopped, and irq_req and irq_level are zero.
- R2: Register addresses are: 0 is preload bits [15:8], 1 is preload bits [7:0], 2 is count bits [15:8], 3 is count bits [7:0], 4 is control, and 5 is interrupt control. Only addresses 0, 1, 4 and 5 are writable. Writes to any other address, including 6 and 7, are ignored. Addresses 6 and 7 read as 0x00. A read returns, on reg_rdata after the next rising clock edge, the value the register held before that edge.
- R3: Writing 0x03 to control while the timer is stopped starts it and loads the preload value into the counter. Writing 0x03 while it is running has no effect. Control reads 0x03 while running and 0x00 while stopped.
- R4: Writing 0x00 to control stops the timer and clears the counter to zero, and leaves the pending flag unchanged. Any control value other than 0x00 or 0x03 is ignored.
- R5: While running, the counter increases by one on each clock cycle where tick_en is high. It does not change on any other cycle, and it never changes while the timer is stopped.
- R6: A tick that arrives while the counter is 0xFFFF loads the preload value into the counter and sets the pending flag in the same cycle. The period is therefore 65536 minus the preload, measured in ticks.
- R7: In the interrupt-control byte, bits [2:0] are the priority level, bit 3 is the enable, bit 7 is the pending flag, and bits [6:4] read as zero. A write stores the level and the enable bits. irq_level always shows the stored level.
- R8: A write to interrupt control with bit 7 set clears the pending flag. With bit 7 clear, the write leaves the flag unchanged.
- R9: If an acknowledge write and a rollover occur in the same cycle, the pending flag ends up set.
- R10: The pending flag sets on rollover whether or not the enable bit is set. irq_req equals the pending flag AND the enable bit, from the same clock edge at which either of them changes.
- R11: Writing the preload while the timer is running does not change the counter. The new value is used at the next rollover or start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | 160 kHz count enable from an external prescaler |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Interrupt request (pending and enabled) |
| irq_level | output | 3 | Stored interrupt priority level |

## Verification
A wrong counter value is visible on the next read of the count bytes, one cycle after the address is applied. A counter that reloads at the wrong time shifts the instant at which the pending bit first reads back set. A wrong pending or enable state reaches irq_req on the same edge where the flag was meant to change. The bench therefore samples the pins and the interrupt byte directly after each tick burst, acknowledge and collision. It also times a full 16-tick period, so that an off-by-one in the reload shows up as an early or late pending bit.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  // control command encodings
  localparam logic [7:0] CTL_HALT = 8'h00;
  localparam logic [7:0] CTL_RUN  = 8'h03;
  // interrupt-control byte layout
  localparam int IRQ_LVL_W    = 3;
  localparam int IRQ_EN_BIT   = 3;
  localparam int IRQ_PEND_BIT = 7;
endpackage

// File: rtl/ivl_timer_decode.sv
module ivl_timer_decode
  import ivl_timer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NB     = 2,
  parameter int ADDR_W = 3,
  parameter int LVL_W  = IRQ_LVL_W
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NB-1:0]     pl_we,
  output logic              cmd_clear,
  output logic              cmd_start,
  output logic              irq_we,
  output logic [LVL_W-1:0]  w_lvl,
  output logic              w_en,
  output logic              w_ack
);
  localparam int CTL_A = 2 * NB;
  localparam int IRQ_A = 2 * NB + 1;

  // preload byte i (i = 0 least significant) sits at address NB-1-i
  generate
    for (genvar i = 0; i < NB; i++) begin : g_pl_we
      assign pl_we[i] = wr && (addr == ADDR_W'(NB - 1 - i));
    end
  endgenerate

  logic ctl_hit;
  assign ctl_hit   = wr && (addr == ADDR_W'(CTL_A));
  assign cmd_clear = ctl_hit && (wdata == CTL_HALT);
  assign cmd_start = ctl_hit && (wdata == CTL_RUN);

  assign irq_we = wr && (addr == ADDR_W'(IRQ_A));
  assign w_lvl  = wdata[LVL_W-1:0];
  assign w_en   = wdata[IRQ_EN_BIT];
  assign w_ack  = irq_we && wdata[IRQ_PEND_BIT];
endmodule

// File: rtl/ivl_timer_count.sv
module ivl_timer_count #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8,
  parameter int NB     = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [NB-1:0]     pl_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              cmd_clear,
  input  logic              cmd_start,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  preload,
  output logic              running,
  output logic              ovf
);
  // preload register, one byte lane per write strobe
  generate
    for (genvar i = 0; i < NB; i++) begin : g_pl
      always_ff @(posedge clk) begin
        if (rst)
          preload[i*DATA_W +: DATA_W] <= '0;
        else if (pl_we[i])
          preload[i*DATA_W +: DATA_W] <= wdata;
      end
    end
  endgenerate

  logic at_top;
  assign at_top = (cnt == {CNT_W{1'b1}});
  assign ovf    = running && tick && !cmd_clear && at_top;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (cmd_clear) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (cmd_start && !running) begin
      cnt     <= preload;
      running <= 1'b1;
    end else if (running && tick) begin
      cnt <= at_top ? preload : cnt + 1'b1;
    end
  end

  a_r4_clear_stops: assert property (@(posedge clk) disable iff (rst)
    cmd_clear |=> (cnt == '0) && !running);
  a_r3_start_loads: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !running && !cmd_clear) |=> running && (cnt == $past(preload)));
  a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
    (!tick && !cmd_clear && !(cmd_start && !running)) |=> $stable(cnt));
  a_r6_reload_on_wrap: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (cnt == $past(preload)));
endmodule

// File: rtl/ivl_timer_irq.sv
module ivl_timer_irq #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ovf,
  input  logic             irq_we,
  input  logic [LVL_W-1:0] w_lvl,
  input  logic             w_en,
  input  logic             w_ack,
  output logic             pend,
  output logic             en,
  output logic [LVL_W-1:0] lvl,
  output logic             irq_req
);
  logic pend_nxt, en_nxt;

  // a rollover in the same cycle as an acknowledge keeps the flag set
  assign pend_nxt = ovf ? 1'b1 : (w_ack ? 1'b0 : pend);
  assign en_nxt   = irq_we ? w_en : en;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      en      <= 1'b0;
      lvl     <= '0;
      irq_req <= 1'b0;
    end else begin
      pend    <= pend_nxt;
      en      <= en_nxt;
      irq_req <= pend_nxt && en_nxt;
      if (irq_we)
        lvl <= w_lvl;
    end
  end

  a_r9_rollover_wins: assert property (@(posedge clk) disable iff (rst)
    ovf |=> pend);
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (w_ack && !ovf) |=> !pend);
  a_r10_req_matches: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> (irq_req == (pend && en)));
  a_r7_level_stored: assert property (@(posedge clk) disable iff (rst)
    irq_we |=> (lvl == $past(w_lvl)));
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int DATA_W   = 8,
  parameter int LVL_W    = IRQ_LVL_W,
  localparam int NB      = CNT_W / DATA_W,
  localparam int ADDR_W  = $clog2(2 * NB + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_level
);
  localparam int CTL_A = 2 * NB;
  localparam int IRQ_A = 2 * NB + 1;

  logic [NB-1:0]    pl_we;
  logic             cmd_clear, cmd_start, irq_we, w_en, w_ack;
  logic [LVL_W-1:0] w_lvl;
  logic [CNT_W-1:0] cnt, preload;
  logic             running, ovf, pend, en;

  ivl_timer_decode #(
    .DATA_W(DATA_W), .NB(NB), .ADDR_W(ADDR_W), .LVL_W(LVL_W)
  ) u_dec (
    .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .pl_we(pl_we), .cmd_clear(cmd_clear), .cmd_start(cmd_start),
    .irq_we(irq_we), .w_lvl(w_lvl), .w_en(w_en), .w_ack(w_ack)
  );

  ivl_timer_count #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .NB(NB)
  ) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_en), .pl_we(pl_we), .wdata(reg_wdata),
    .cmd_clear(cmd_clear), .cmd_start(cmd_start),
    .cnt(cnt), .preload(preload), .running(running), .ovf(ovf)
  );

  ivl_timer_irq #(
    .LVL_W(LVL_W)
  ) u_irq (
    .clk(clk), .rst(rst), .ovf(ovf), .irq_we(irq_we), .w_lvl(w_lvl),
    .w_en(w_en), .w_ack(w_ack), .pend(pend), .en(en), .lvl(irq_level),
    .irq_req(irq_req)
  );

  // read mux, registered onto the port
  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NB; i++) begin
      if (reg_addr == ADDR_W'(NB - 1 - i))
        rd_mux = preload[i*DATA_W +: DATA_W];
      if (reg_addr == ADDR_W'(2 * NB - 1 - i))
        rd_mux = cnt[i*DATA_W +: DATA_W];
    end
    if (reg_addr == ADDR_W'(CTL_A))
      rd_mux = running ? CTL_RUN : CTL_HALT;
    if (reg_addr == ADDR_W'(IRQ_A)) begin
      rd_mux[LVL_W-1:0]    = irq_level;
      rd_mux[IRQ_EN_BIT]   = en;
      rd_mux[IRQ_PEND_BIT] = pend;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else
      reg_rdata <= rd_mux;
  end

  a_r2_rdata_follows: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == ADDR_W'(CTL_A)) |=> (reg_rdata == ($past(running) ? CTL_RUN : CTL_HALT)));
endmodule

// File: tb/ivl_timer_tb.sv
`timescale 1ns/1ps
module ivl_timer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq_req;
  logic [2:0] irq_level;

  always #2.5 clk = ~clk;

  ivl_timer u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_req(irq_req), .irq_level(irq_level)
  );

  typedef struct {
    bit         is_pin;
    logic [7:0] exp;
    string      tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;
  logic rd_stb = 1'b0, pin_stb = 1'b0;
  logic rd_d = 1'b0, pin_d = 1'b0;

  // monitor: compare one cycle after each strobe
  always @(posedge clk) begin
    rd_d  <= rd_stb;
    pin_d <= pin_stb;
  end

  always @(negedge clk) begin
    if (rd_d || pin_d) begin
      if (sb_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL scoreboard empty: got %02h expected none", reg_rdata);
      end else begin
        exp_t e;
        logic [7:0] act;
        e = sb_q.pop_front();
        act = e.is_pin ? {irq_req, 4'b0000, irq_level} : reg_rdata;
        n_vec++;
        if (act !== e.exp) begin
          n_bad++;
          $display("FAIL %s: got %02h expected %02h", e.tag, act, e.exp);
        end
      end
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_t it;
    it.is_pin = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    reg_addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic chk_pins(input logic req, input logic [2:0] lvl, input string tag);
    exp_t it;
    it.is_pin = 1'b1; it.exp = {req, 4'b0000, lvl}; it.tag = tag;
    sb_q.push_back(it);
    pin_stb = 1'b1;
    @(negedge clk);
    pin_stb = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd_reg(3'd2, 8'h00, "R1 count hi");
    rd_reg(3'd3, 8'h00, "R1 count lo");
    rd_reg(3'd4, 8'h00, "R1 control");
    rd_reg(3'd5, 8'h00, "R1 irq ctl");
    rd_reg(3'd0, 8'h00, "R1 preload hi");
    chk_pins(1'b0, 3'd0, "R1 irq pins");

    // R2 map and ignored writes
    wr_reg(3'd0, 8'hFF);
    wr_reg(3'd1, 8'hFC);
    rd_reg(3'd0, 8'hFF, "R2 preload hi");
    rd_reg(3'd1, 8'hFC, "R2 preload lo");
    wr_reg(3'd6, 8'hAA);
    wr_reg(3'd2, 8'h55);
    rd_reg(3'd6, 8'h00, "R2 unused addr");
    rd_reg(3'd2, 8'h00, "R2 count not writable");
    rd_reg(3'd0, 8'hFF, "R2 preload kept");

    // R7 level and enable
    wr_reg(3'd5, 8'h0D);
    rd_reg(3'd5, 8'h0D, "R7 irq ctl readback");
    chk_pins(1'b0, 3'd5, "R7 level pin");

    // R5 stopped timer ignores ticks
    ticks(2);
    rd_reg(3'd3, 8'h00, "R5 stopped no count");

    // R3 start loads preload
    wr_reg(3'd4, 8'h03);
    rd_reg(3'd4, 8'h03, "R3 control running");
    rd_reg(3'd3, 8'hFC, "R3 count lo loaded");
    rd_reg(3'd2, 8'hFF, "R3 count hi loaded");
    repeat (4) @(negedge clk);
    rd_reg(3'd3, 8'hFC, "R5 no tick no count");

    // R5 / R6 counting up to wrap
    ticks(3);
    rd_reg(3'd3, 8'hFF, "R5 count lo at top");
    rd_reg(3'd5, 8'h0D, "R6 no pend before wrap");
    ticks(1);
    rd_reg(3'd3, 8'hFC, "R6 reload lo");
    rd_reg(3'd2, 8'hFF, "R6 reload hi");
    rd_reg(3'd5, 8'h8D, "R6 pend set");
    chk_pins(1'b1, 3'd5, "R10 req asserted");

    // R8 acknowledge
    wr_reg(3'd5, 8'h8D);
    rd_reg(3'd5, 8'h0D, "R8 ack clears");
    chk_pins(1'b0, 3'd5, "R8 req dropped");

    // R10 pending sets while disabled
    wr_reg(3'd5, 8'h05);
    ticks(4);
    rd_reg(3'd5, 8'h85, "R10 pend while disabled");
    chk_pins(1'b0, 3'd5, "R10 no req disabled");
    wr_reg(3'd5, 8'h0D);
    rd_reg(3'd5, 8'h8D, "R8 bit7 zero keeps pend");
    chk_pins(1'b1, 3'd5, "R10 req on enable");
    wr_reg(3'd5, 8'h8D);

    // R9 acknowledge collides with wrap
    ticks(3);
    rd_reg(3'd3, 8'hFF, "R9 setup at top");
    reg_addr = 3'd5; reg_wdata = 8'h8D; reg_wr = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
    rd_reg(3'd5, 8'h8D, "R9 wrap wins over ack");
    rd_reg(3'd3, 8'hFC, "R9 reload on collision");
    wr_reg(3'd5, 8'h8D);

    // R3 start while running ignored
    ticks(1);
    wr_reg(3'd4, 8'h03);
    rd_reg(3'd3, 8'hFD, "R3 restart ignored");

    // R11 preload write while running
    wr_reg(3'd0, 8'h00);
    wr_reg(3'd1, 8'h10);
    rd_reg(3'd3, 8'hFD, "R11 count lo unchanged");
    rd_reg(3'd2, 8'hFF, "R11 count hi unchanged");
    ticks(3);
    rd_reg(3'd3, 8'h10, "R11 new reload lo");
    rd_reg(3'd2, 8'h00, "R11 new reload hi");
    rd_reg(3'd5, 8'h8D, "R6 pend after reload");

    // R4 other control values ignored
    wr_reg(3'd4, 8'h01);
    rd_reg(3'd4, 8'h03, "R4 bad command ignored");
    ticks(1);
    rd_reg(3'd3, 8'h11, "R4 still counting");

    // R4 halt clears and stops
    wr_reg(3'd4, 8'h00);
    rd_reg(3'd4, 8'h00, "R4 control stopped");
    rd_reg(3'd3, 8'h00, "R4 count lo cleared");
    rd_reg(3'd2, 8'h00, "R4 count hi cleared");
    rd_reg(3'd5, 8'h8D, "R4 pend kept");
    ticks(2);
    rd_reg(3'd3, 8'h00, "R4 halted no count");

    // R6 period for 10 kHz (preload 0xFFF0, 16 ticks)
    wr_reg(3'd5, 8'h8D);
    wr_reg(3'd0, 8'hFF);
    wr_reg(3'd1, 8'hF0);
    wr_reg(3'd4, 8'h03);
    ticks(15);
    rd_reg(3'd3, 8'hFF, "R6 period tick 15");
    rd_reg(3'd5, 8'h0D, "R6 no pend at 15");
    ticks(1);
    rd_reg(3'd3, 8'hF0, "R6 period reload");
    rd_reg(3'd5, 8'h8D, "R6 pend at 16");

    // R7 level change, R8 ack with disable
    wr_reg(3'd5, 8'h0A);
    chk_pins(1'b1, 3'd2, "R7 new level");
    wr_reg(3'd5, 8'h80);
    chk_pins(1'b0, 3'd0, "R7 level zero");
    rd_reg(3'd5, 8'h00, "R8 cleared and disabled");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule